// File: doc/BRIEF.md
# Sectored Queue Flag Status Bus

This block carries per-queue watermark status for up to sixteen queues over a narrow eight-lane bus. The queues are split into two sectors of eight. Queues 1 to 8 form the low sector and queues 9 to 16 form the high sector. The block builds two such buses. The almost-full bus runs on the write-side clock and reads a sixteen-bit almost-full vector. The almost-empty bus runs on the read-side clock and reads a sixteen-bit almost-empty vector. Each bus also has a one-bit sector indicator that tells the monitoring logic which sector the lanes carry at that moment.

One mode input, shared by both buses, chooses how sectors are shown:
- In polled mode, each bus alternates between its two sectors on every rising edge of its own clock.
- In direct mode, each bus loads its sector from its own sector-select input.

The number of configured queues masks off lanes that have no queue behind them. Both sectors are still visited even when eight or fewer queues exist.

Each bus is driven by a two-state machine with these states and transitions:
- `SEC_LOW` shows queues 1 to 8. It is the reset state.
- `SEC_HIGH` shows queues 9 to 16.
- ADVANCE (polled mode): each state moves to the other state at each edge.
- LOAD (direct mode): the next state is the sector-select value.

The lanes are driven combinationally from the current state and the live flag vector.

Top module: `sector_flag_bus`

## Requirements
- R1: While a channel's reset is low, and right after it is released, its sector indicator is 0. Sector indicator encoding: 0 = queues 1 to 8, 1 = queues 9 to 16.
- R2: In polled mode (`direct_mode` = 0), the sector indicator of a channel inverts at every rising edge of that channel's clock.
- R3: In direct mode (`direct_mode` = 1), the sector indicator takes the value of the channel's sector-select input sampled at the previous rising edge of its clock.
- R4: Lane i (0 to 7) of a bus carries flag bit i when the sector indicator is 0, and flag bit 8+i when it is 1. This holds whenever that queue index is below the configured count. The lanes follow the flag vector combinationally.
- R5: A lane whose queue index (sector*8 + i) is not below `queue_count` is driven to 0. `queue_count` is an unsigned queue number from 0 to 16; larger values act as 16.
- R6: Polled mode alternates between both sectors even when `queue_count` is 8 or less. In that case the high sector shows all-zero lanes.
- R7: The two channels run independently on their own clocks, resets and sector-select inputs, under the single shared mode input.
- R8: On a change from direct to polled mode, the first edge in polled mode moves to the sector opposite the one currently shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Clock of the almost-full channel |
| wr_rst_n | input | 1 | Asynchronous active-low reset, almost-full channel |
| rd_clk | input | 1 | Clock of the almost-empty channel |
| rd_rst_n | input | 1 | Asynchronous active-low reset, almost-empty channel |
| direct_mode | input | 1 | 1 = direct sector select, 0 = polled |
| queue_count | input | 5 | Number of configured queues (0 to 16) |
| almost_full_vec | input | 16 | Per-queue almost-full flags, bit q = queue q+1 |
| almost_empty_vec | input | 16 | Per-queue almost-empty flags, bit q = queue q+1 |
| wr_sector_sel | input | 1 | Direct-mode sector choice for the almost-full bus |
| rd_sector_sel | input | 1 | Direct-mode sector choice for the almost-empty bus |
| af_bus | output | 8 | Almost-full lanes of the shown sector |
| af_sector | output | 1 | Sector shown on `af_bus` |
| ae_bus | output | 8 | Almost-empty lanes of the shown sector |
| ae_sector | output | 1 | Sector shown on `ae_bus` |

## Verification
The only internal state is the sector register of each channel. A wrong value shows on the sector indicator and on the lanes at the first falling edge after the faulty clock edge. For example, a missed ADVANCE or a wrong LOAD is visible within half a cycle. Errors in lane masking appear only for certain queue counts, so the bench sweeps the count across 0, 3, 8, 14 and 16 in both modes. It also varies the flag vectors each cycle so that a stuck or swapped lane cannot hide.

// File: rtl/sector_flag_pkg.sv
package sector_flag_pkg;

    // Two sectors: which half of the queue set the lanes show.
    typedef enum logic {
        SEC_LOW  = 1'b0,
        SEC_HIGH = 1'b1
    } sector_e;

endpackage

// File: rtl/sector_step_fsm.sv
module sector_step_fsm
    import sector_flag_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    direct_mode,
    input  logic    sector_sel,
    output sector_e sector
);

    sector_e state_q;
    sector_e state_d;

    // Next-state: ADVANCE in polled mode, LOAD in direct mode.
    always_comb begin
        unique case (state_q)
            SEC_LOW:  state_d = direct_mode ? sector_e'(sector_sel) : SEC_HIGH;
            SEC_HIGH: state_d = direct_mode ? sector_e'(sector_sel) : SEC_LOW;
            default:  state_d = SEC_LOW;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEC_LOW;
        else        state_q <= state_d;
    end

    // Output process.
    always_comb sector = state_q;

    always @(posedge clk) begin
        if (!rst_n) AST_RESET_LOW: assert (sector == SEC_LOW); // R1
    end

    AST_POLL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        !direct_mode |=> sector != $past(sector)); // R2

    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        direct_mode |=> sector == sector_e'($past(sector_sel))); // R3

endmodule

// File: rtl/sector_lane_select.sv
module sector_lane_select
    import sector_flag_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int CNT_W  = 5
) (
    input  sector_e                sector,
    input  logic [2*LANES-1:0]     flags,
    input  logic [CNT_W-1:0]       queue_count,
    output logic [LANES-1:0]       bus
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int LO_Q = i;
        localparam int HI_Q = LANES + i;
        logic live;
        logic pick;
        always_comb begin
            if (sector == SEC_HIGH) begin
                live = queue_count > CNT_W'(HI_Q);
                pick = flags[HI_Q];
            end else begin
                live = queue_count > CNT_W'(LO_Q);
                pick = flags[LO_Q];
            end
            bus[i] = live & pick;
        end
    end

endmodule

// File: rtl/sector_flag_channel.sv
module sector_flag_channel
    import sector_flag_pkg::*;
#(
    parameter int LANES = 8,
    parameter int CNT_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               direct_mode,
    input  logic               sector_sel,
    input  logic [2*LANES-1:0] flags,
    input  logic [CNT_W-1:0]   queue_count,
    output logic [LANES-1:0]   bus,
    output logic               sector_out
);

    localparam int QUEUES = 2 * LANES;

    sector_e sector;

    sector_step_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .direct_mode (direct_mode),
        .sector_sel  (sector_sel),
        .sector      (sector)
    );

    sector_lane_select #(
        .LANES (LANES),
        .CNT_W (CNT_W)
    ) u_lanes (
        .sector      (sector),
        .flags       (flags),
        .queue_count (queue_count),
        .bus         (bus)
    );

    assign sector_out = sector;

    AST_FULL_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (queue_count >= CNT_W'(QUEUES) && sector == SEC_LOW)
            |-> bus == flags[LANES-1:0]); // R4

    AST_UPPER_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (queue_count <= CNT_W'(LANES) && sector == SEC_HIGH) |-> bus == '0); // R5

endmodule

// File: rtl/sector_flag_bus.sv
module sector_flag_bus #(
    parameter int LANES = 8,
    parameter int QUEUES = 2 * LANES,
    parameter int CNT_W = $clog2(QUEUES + 1)
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              direct_mode,
    input  logic [CNT_W-1:0]  queue_count,
    input  logic [QUEUES-1:0] almost_full_vec,
    input  logic [QUEUES-1:0] almost_empty_vec,
    input  logic              wr_sector_sel,
    input  logic              rd_sector_sel,
    output logic [LANES-1:0]  af_bus,
    output logic              af_sector,
    output logic [LANES-1:0]  ae_bus,
    output logic              ae_sector
);

    // Almost-full channel, write-side clock.
    sector_flag_channel #(
        .LANES (LANES),
        .CNT_W (CNT_W)
    ) u_af (
        .clk         (wr_clk),
        .rst_n       (wr_rst_n),
        .direct_mode (direct_mode),
        .sector_sel  (wr_sector_sel),
        .flags       (almost_full_vec),
        .queue_count (queue_count),
        .bus         (af_bus),
        .sector_out  (af_sector)
    );

    // Almost-empty channel, read-side clock (R7).
    sector_flag_channel #(
        .LANES (LANES),
        .CNT_W (CNT_W)
    ) u_ae (
        .clk         (rd_clk),
        .rst_n       (rd_rst_n),
        .direct_mode (direct_mode),
        .sector_sel  (rd_sector_sel),
        .flags       (almost_empty_vec),
        .queue_count (queue_count),
        .bus         (ae_bus),
        .sector_out  (ae_sector)
    );

endmodule

// File: tb/test_sector_flag_bus.sv
module test_sector_flag_bus;

    localparam int CLK_PERIOD    = 10;
    localparam int RD_CLK_PERIOD = 16;
    localparam int WATCHDOG_CYC  = 20000;

    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        wr_rst_n = 1'b0;
    logic        rd_rst_n = 1'b0;
    logic        direct_mode = 1'b0;
    logic [4:0]  queue_count = 5'd16;
    logic [15:0] almost_full_vec = '0;
    logic [15:0] almost_empty_vec = '0;
    logic        wr_sector_sel = 1'b0;
    logic        rd_sector_sel = 1'b0;
    logic [7:0]  af_bus;
    logic        af_sector;
    logic [7:0]  ae_bus;
    logic        ae_sector;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit switched_wr = 0;
    int wsec = 0;
    int rsec = 0;
    bit prev_direct_wr = 0;

    always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
    always #(RD_CLK_PERIOD/2) rd_clk = ~rd_clk;

    sector_flag_bus i_sector_flag_bus (
        .wr_clk           (wr_clk),
        .wr_rst_n         (wr_rst_n),
        .rd_clk           (rd_clk),
        .rd_rst_n         (rd_rst_n),
        .direct_mode      (direct_mode),
        .queue_count      (queue_count),
        .almost_full_vec  (almost_full_vec),
        .almost_empty_vec (almost_empty_vec),
        .wr_sector_sel    (wr_sector_sel),
        .rd_sector_sel    (rd_sector_sel),
        .af_bus           (af_bus),
        .af_sector        (af_sector),
        .ae_bus           (ae_bus),
        .ae_sector        (ae_sector)
    );

    function automatic logic [7:0] expect_bus(int sec, logic [15:0] v, int cnt);
        logic [7:0] r;
        int limit;
        limit = (cnt > 16) ? 16 : cnt;
        for (int i = 0; i < 8; i++) begin
            int q;
            q = sec * 8 + i;
            r[i] = (q < limit) ? v[q] : 1'b0;
        end
        return r;
    endfunction

    task automatic check(string tag, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, actual, expected);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Reference model, write channel.
    always @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            wsec = 0;
            switched_wr = 0;
        end else begin
            switched_wr = prev_direct_wr && !direct_mode;
            wsec = direct_mode ? int'(wr_sector_sel) : 1 - wsec;
        end
        prev_direct_wr = direct_mode;
    end

    // Reference model, read channel.
    always @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) rsec = 0;
        else           rsec = direct_mode ? int'(rd_sector_sel) : 1 - rsec;
    end

    // Compare on falling edges.
    always @(negedge wr_clk) begin
        if (!wr_rst_n) begin
            check("R1 af_sector in reset", int'(af_sector), 0);
        end else begin
            if (switched_wr) check("R8 af_sector after mode switch", int'(af_sector), wsec);
            else if (direct_mode) check("R3 af_sector direct", int'(af_sector), wsec);
            else if (queue_count <= 8) check("R6 af_sector polled small count", int'(af_sector), wsec);
            else check("R2 af_sector polled", int'(af_sector), wsec);
            if (wsec == 1 && queue_count < 16)
                check("R5 af_bus masked lanes", int'(af_bus),
                      int'(expect_bus(wsec, almost_full_vec, int'(queue_count))));
            else
                check("R4 af_bus lanes", int'(af_bus),
                      int'(expect_bus(wsec, almost_full_vec, int'(queue_count))));
        end
    end

    always @(negedge rd_clk) begin
        if (!rd_rst_n) begin
            check("R1 ae_sector in reset", int'(ae_sector), 0);
        end else begin
            check("R7 ae_sector", int'(ae_sector), rsec);
            check("R7 ae_bus", int'(ae_bus),
                  int'(expect_bus(rsec, almost_empty_vec, int'(queue_count))));
        end
    end

    task automatic wr_cycles(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge wr_clk);
            #1;
            almost_full_vec  = 16'($urandom);
            almost_empty_vec = 16'($urandom);
            wr_sector_sel    = 1'($urandom);
            rd_sector_sel    = 1'($urandom);
        end
    endtask

    initial begin
        repeat (3) @(negedge wr_clk);
        #1;
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        // Polled with each queue count (R2, R4, R5, R6).
        queue_count = 5'd16; wr_cycles(40);
        queue_count = 5'd14; wr_cycles(40);
        queue_count = 5'd8;  wr_cycles(30);
        queue_count = 5'd3;  wr_cycles(30);
        queue_count = 5'd0;  wr_cycles(20);
        queue_count = 5'd20; wr_cycles(20);
        // Direct mode (R3).
        direct_mode = 1'b1;
        queue_count = 5'd14; wr_cycles(60);
        queue_count = 5'd16; wr_cycles(30);
        // Back to polled (R8).
        direct_mode = 1'b0; wr_cycles(20);
        direct_mode = 1'b1; wr_cycles(5);
        direct_mode = 1'b0; wr_cycles(20);
        // Reset of the write side only (R1, R7).
        wr_rst_n = 1'b0; wr_cycles(4);
        wr_rst_n = 1'b1; wr_cycles(30);
        done = 1;
        @(negedge wr_clk);
        finish_run();
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge wr_clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: actual=running expected=done");
            finish_run();
        end
    end

endmodule